// File: doc/BRIEF.md
# Speculative Store Buffer Pool

This block holds the stores of speculative threads until each thread is known to be correct, then hands them to the shared second-level cache. A pool of line buffers has one more buffer than there are cores. Whenever a thread starts, the scheduler claims a free buffer. The order of claims is the program order of the threads. Every store that arrives on the write bus carries the index of its thread's buffer. Inside a buffer, the store lands in a line entry that holds an address tag, the line data and a mask of the bytes written.

When a thread completes, its buffer is marked finished. Finished buffers drain to the cache write port one entry per cycle, and always in claim order: a younger thread that finishes first waits behind its elders. If a thread is found to have read data too early, its buffer is emptied. Other buffers and everything already written to the cache are left alone. Because of the spare buffer, the oldest finished thread can drain while every core runs a new speculative thread.

Top module: `specWriteBuffers`

## Requirements
- R1: A claim (`allocValid` while `allocReady` is high) grants the lowest-indexed buffer that is not owned, shown on `allocBuf`. `allocReady` is low exactly when every buffer is owned.
- R2: No cache write (`l2Valid`) comes from a buffer before a commit has marked it finished. Only the oldest owned buffer may drain.
- R3: Finished buffers drain in the order they were claimed, whatever the order of their commits. A younger finished buffer waits until every older buffer has drained and been freed.
- R4: The pool has one buffer more than the cores (5 with 4 cores), and all of them may be owned at once. While the oldest buffer drains, stores to the other owned buffers are still accepted.
- R5: A violation on an owned, unfinished buffer empties that buffer in one cycle. The buffer stays owned and keeps its place in the order, and other buffers are not touched. A store to the same buffer in the same cycle is dropped.
- R6: Each buffer has 4 line entries. A store whose line address matches a valid entry merges into it: bytes whose `stMask` bit is set are overwritten and the other bytes are kept, and the entry's mask becomes the OR of the two masks. A store to a new line takes the lowest free entry, and its unwritten bytes read as zero. Bit i of `stMask` covers data bits 8i+7..8i.
- R7: `stStall` is high in a cycle where a store to an owned, unfinished buffer needs a new entry and all 4 entries are valid. That store is not written.
- R8: A draining buffer puts out one valid entry per cycle, lowest entry index first, with its address, data and byte mask on the cache port. In the cycle after its last entry, the buffer puts out nothing and is freed.
- R9: Stores to a buffer that is not owned or is already finished, and commits to a buffer that is not owned, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Request to claim a buffer for a new thread |
| allocReady | output | 1 | A free buffer exists |
| allocBuf | output | 3 | Index of the buffer a claim receives |
| stValid | input | 1 | Store present on the write bus |
| stBuf | input | 3 | Buffer index the store belongs to |
| stAddr | input | 16 | Line address of the store |
| stData | input | 64 | Store data, one full line |
| stMask | input | 8 | Bytes of the line the store writes |
| stStall | output | 1 | Store refused because the buffer is full |
| commitValid | input | 1 | Thread of `commitBuf` completed successfully |
| commitBuf | input | 3 | Buffer being marked finished |
| violValid | input | 1 | Thread of `violBuf` misspeculated |
| violBuf | input | 3 | Buffer to be emptied |
| l2Valid | output | 1 | Cache write this cycle |
| l2Addr | output | 16 | Line address of the cache write |
| l2Data | output | 64 | Line data of the cache write |
| l2Mask | output | 8 | Bytes of the line to write |

## Verification
Several directed sequences are used. Commits arrive in reverse claim order, to show whether drain follows claim order or commit order. A buffer is filled to capacity and then hit again, which separates refusal of a new line from merging into an existing one. A violation lands in the same cycle as a store to the same buffer, to show that only that buffer loses state. All five buffers are held while the oldest drains, and stores are aimed at unowned or finished buffers. Random claims, stores over a small set of line addresses, out-of-order commits and rare violations are then checked cycle by cycle against a bench model of the requirements.

// File: rtl/wbPkg.sv
package wbPkg;
  parameter int WB_CORES      = 4;
  parameter int WB_ENTRIES    = 4;
  parameter int WB_LINE_BYTES = 8;
  parameter int WB_ADDR_W     = 16;

  localparam int WB_BUFS = WB_CORES + 1;
  localparam int BUF_W   = $clog2(WB_BUFS);
  localparam int ENT_W   = $clog2(WB_ENTRIES);
  localparam int LINE_W  = WB_LINE_BYTES * 8;
  localparam int CNT_W   = $clog2(WB_BUFS + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;
    logic             wrHit;
    logic [BUF_W-1:0] wrBuf;
    logic [ENT_W-1:0] wrEntry;
    logic             clrEn;
    logic [BUF_W-1:0] clrBuf;
    logic             drainEn;
    logic [BUF_W-1:0] drainBuf;
    logic [ENT_W-1:0] drainEntry;
  } wbStrobe_t;

  // lookup results from datapath to control
  typedef struct packed {
    logic             stHit;
    logic [ENT_W-1:0] stHitIdx;
    logic             stFree;
    logic [ENT_W-1:0] stFreeIdx;
    logic             headAny;
    logic [ENT_W-1:0] headIdx;
  } wbStatus_t;
endpackage

// File: rtl/wbData.sv
module wbData
  import wbPkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  wbStrobe_t                strobe,
  input  logic [BUF_W-1:0]         stBuf,
  input  logic [WB_ADDR_W-1:0]     stAddr,
  input  logic [LINE_W-1:0]        stData,
  input  logic [WB_LINE_BYTES-1:0] stMask,
  input  logic [BUF_W-1:0]         headBuf,
  output wbStatus_t                status,
  output logic [WB_ADDR_W-1:0]     l2Addr,
  output logic [LINE_W-1:0]        l2Data,
  output logic [WB_LINE_BYTES-1:0] l2Mask
);
  logic                     entValid [WB_BUFS][WB_ENTRIES];
  logic [WB_ADDR_W-1:0]     entTag   [WB_BUFS][WB_ENTRIES];
  logic [LINE_W-1:0]        entData  [WB_BUFS][WB_ENTRIES];
  logic [WB_LINE_BYTES-1:0] entMask  [WB_BUFS][WB_ENTRIES];
  logic [WB_BUFS-1:0]       rowAny;

  logic [BUF_W-1:0] stSel;
  logic [BUF_W-1:0] hdSel;

  assign stSel = (int'(stBuf) < WB_BUFS) ? stBuf : '0;
  assign hdSel = (int'(headBuf) < WB_BUFS) ? headBuf : '0;

  always_comb begin
    status = '0;
    for (int e = WB_ENTRIES - 1; e >= 0; e--) begin
      if (entValid[stSel][e] && entTag[stSel][e] == stAddr) begin
        status.stHit    = 1'b1;
        status.stHitIdx = ENT_W'(e);
      end
      if (!entValid[stSel][e]) begin
        status.stFree    = 1'b1;
        status.stFreeIdx = ENT_W'(e);
      end
      if (entValid[hdSel][e]) begin
        status.headAny = 1'b1;
        status.headIdx = ENT_W'(e);
      end
    end
  end

  always_comb begin
    for (int b = 0; b < WB_BUFS; b++) begin
      rowAny[b] = 1'b0;
      for (int e = 0; e < WB_ENTRIES; e++) rowAny[b] = rowAny[b] | entValid[b][e];
    end
  end

  assign l2Addr = entTag[hdSel][status.headIdx];
  assign l2Data = entData[hdSel][status.headIdx];
  assign l2Mask = entMask[hdSel][status.headIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < WB_BUFS; b++) begin
        for (int e = 0; e < WB_ENTRIES; e++) begin
          entValid[b][e] <= 1'b0;
          entTag[b][e]   <= '0;
          entData[b][e]  <= '0;
          entMask[b][e]  <= '0;
        end
      end
    end else begin
      for (int b = 0; b < WB_BUFS; b++) begin
        for (int e = 0; e < WB_ENTRIES; e++) begin
          if (strobe.clrEn && int'(strobe.clrBuf) == b) begin
            entValid[b][e] <= 1'b0;
          end else if (strobe.drainEn && int'(strobe.drainBuf) == b &&
                       int'(strobe.drainEntry) == e) begin
            entValid[b][e] <= 1'b0;
          end else if (strobe.wrEn && int'(strobe.wrBuf) == b &&
                       int'(strobe.wrEntry) == e) begin
            entValid[b][e] <= 1'b1;
            entTag[b][e]   <= stAddr;
            entMask[b][e]  <= strobe.wrHit ? (entMask[b][e] | stMask) : stMask;
            for (int k = 0; k < WB_LINE_BYTES; k++) begin
              if (stMask[k])          entData[b][e][k*8 +: 8] <= stData[k*8 +: 8];
              else if (!strobe.wrHit) entData[b][e][k*8 +: 8] <= 8'h00;
            end
          end
        end
      end
    end
  end

  // a new line never overwrites a live entry
  p_new_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn && !strobe.wrHit |-> !entValid[strobe.wrBuf][strobe.wrEntry]);

  // drain only reads live entries
  p_drain_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.drainEn |-> entValid[strobe.drainBuf][strobe.drainEntry]);

  // a violation leaves its buffer empty
  p_clear_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrEn |=> !rowAny[$past(strobe.clrBuf)]);
endmodule

// File: rtl/wbCtrl.sv
module wbCtrl
  import wbPkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allocValid,
  output logic             allocReady,
  output logic [BUF_W-1:0] allocBuf,
  input  logic             stValid,
  input  logic [BUF_W-1:0] stBuf,
  output logic             stStall,
  input  logic             commitValid,
  input  logic [BUF_W-1:0] commitBuf,
  input  logic             violValid,
  input  logic [BUF_W-1:0] violBuf,
  input  wbStatus_t        status,
  output wbStrobe_t        strobe,
  output logic [BUF_W-1:0] headBuf
);
  localparam int IDX_N = 2 ** BUF_W;

  logic [WB_BUFS-1:0] busy;
  logic [WB_BUFS-1:0] done;
  logic [BUF_W-1:0]   ordQ [WB_BUFS];
  logic [BUF_W-1:0]   rdPtr;
  logic [BUF_W-1:0]   wrPtr;
  logic [CNT_W-1:0]   ordCnt;
  logic [IDX_N-1:0]   busyPad;
  logic [IDX_N-1:0]   donePad;

  logic headDone, releaseBuf, allocGo, commitHit, violHit, stLive;

  assign busyPad = IDX_N'(busy);
  assign donePad = IDX_N'(done);

  function automatic logic [BUF_W-1:0] nextPtr(input logic [BUF_W-1:0] p);
    return (int'(p) == WB_BUFS - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    allocReady = ~&busy;
    allocBuf   = '0;
    for (int i = WB_BUFS - 1; i >= 0; i--) if (!busy[i]) allocBuf = BUF_W'(i);
  end

  assign headBuf    = ordQ[rdPtr];
  assign headDone   = (ordCnt != '0) && donePad[headBuf];
  assign releaseBuf = headDone && !status.headAny;
  assign allocGo    = allocValid && allocReady;
  assign commitHit  = commitValid && busyPad[commitBuf] && !donePad[commitBuf];
  assign violHit    = violValid && busyPad[violBuf] && !donePad[violBuf];
  assign stLive     = stValid && busyPad[stBuf] && !donePad[stBuf] &&
                      !(violHit && violBuf == stBuf);
  assign stStall    = stLive && !status.stHit && !status.stFree;

  always_comb begin
    strobe            = '0;
    strobe.wrEn       = stLive && (status.stHit || status.stFree);
    strobe.wrHit      = status.stHit;
    strobe.wrBuf      = stBuf;
    strobe.wrEntry    = status.stHit ? status.stHitIdx : status.stFreeIdx;
    strobe.clrEn      = violHit;
    strobe.clrBuf     = violBuf;
    strobe.drainEn    = headDone && status.headAny;
    strobe.drainBuf   = headBuf;
    strobe.drainEntry = status.headIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= '0;
      done   <= '0;
      rdPtr  <= '0;
      wrPtr  <= '0;
      ordCnt <= '0;
      for (int i = 0; i < WB_BUFS; i++) ordQ[i] <= '0;
    end else begin
      if (allocGo) begin
        busy[allocBuf] <= 1'b1;
        ordQ[wrPtr]    <= allocBuf;
        wrPtr          <= nextPtr(wrPtr);
      end
      if (commitHit) done[commitBuf] <= 1'b1;
      if (releaseBuf) begin
        busy[headBuf] <= 1'b0;
        done[headBuf] <= 1'b0;
        rdPtr         <= nextPtr(rdPtr);
      end
      ordCnt <= ordCnt + CNT_W'(allocGo) - CNT_W'(releaseBuf);
    end
  end

  // a granted buffer is owned and unfinished the next cycle
  p_grant_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    allocGo |=> busyPad[$past(allocBuf)] && !donePad[$past(allocBuf)]);

  // order queue tracks exactly the owned buffers
  p_queue_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ordCnt) <= WB_BUFS) && (int'(ordCnt) == $countones(busy)));

  // finished only while owned
  p_done_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ~busy) == '0);

  // freed head leaves the pool next cycle
  p_release_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    releaseBuf |=> !busyPad[$past(headBuf)]);
endmodule

// File: rtl/specWriteBuffers.sv
module specWriteBuffers
  import wbPkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     allocValid,
  output logic                     allocReady,
  output logic [BUF_W-1:0]         allocBuf,
  input  logic                     stValid,
  input  logic [BUF_W-1:0]         stBuf,
  input  logic [WB_ADDR_W-1:0]     stAddr,
  input  logic [LINE_W-1:0]        stData,
  input  logic [WB_LINE_BYTES-1:0] stMask,
  output logic                     stStall,
  input  logic                     commitValid,
  input  logic [BUF_W-1:0]         commitBuf,
  input  logic                     violValid,
  input  logic [BUF_W-1:0]         violBuf,
  output logic                     l2Valid,
  output logic [WB_ADDR_W-1:0]     l2Addr,
  output logic [LINE_W-1:0]        l2Data,
  output logic [WB_LINE_BYTES-1:0] l2Mask
);
  wbStrobe_t        strobe;
  wbStatus_t        status;
  logic [BUF_W-1:0] headBuf;

  wbCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocReady(allocReady), .allocBuf(allocBuf),
    .stValid(stValid), .stBuf(stBuf), .stStall(stStall),
    .commitValid(commitValid), .commitBuf(commitBuf),
    .violValid(violValid), .violBuf(violBuf),
    .status(status), .strobe(strobe), .headBuf(headBuf)
  );

  wbData u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .stBuf(stBuf), .stAddr(stAddr), .stData(stData), .stMask(stMask),
    .headBuf(headBuf), .status(status),
    .l2Addr(l2Addr), .l2Data(l2Data), .l2Mask(l2Mask)
  );

  assign l2Valid = strobe.drainEn;
endmodule

// File: tb/specWriteBuffers_bench.sv
module specWriteBuffers_bench;
  import wbPkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic allocValid = 1'b0, stValid = 1'b0, commitValid = 1'b0, violValid = 1'b0;
  logic [BUF_W-1:0] stBuf = '0, commitBuf = '0, violBuf = '0;
  logic [WB_ADDR_W-1:0] stAddr = '0;
  logic [LINE_W-1:0] stData = '0;
  logic [WB_LINE_BYTES-1:0] stMask = '0;
  logic allocReady, stStall, l2Valid;
  logic [BUF_W-1:0] allocBuf;
  logic [WB_ADDR_W-1:0] l2Addr;
  logic [LINE_W-1:0] l2Data;
  logic [WB_LINE_BYTES-1:0] l2Mask;

  always #5 clk = ~clk;

  specWriteBuffers u_specWriteBuffers (
    .clk(clk), .rst_n(rst_n),
    .allocValid(allocValid), .allocReady(allocReady), .allocBuf(allocBuf),
    .stValid(stValid), .stBuf(stBuf), .stAddr(stAddr), .stData(stData),
    .stMask(stMask), .stStall(stStall),
    .commitValid(commitValid), .commitBuf(commitBuf),
    .violValid(violValid), .violBuf(violBuf),
    .l2Valid(l2Valid), .l2Addr(l2Addr), .l2Data(l2Data), .l2Mask(l2Mask)
  );

  // reference model of the requirements
  bit                       mValid [WB_BUFS][WB_ENTRIES];
  logic [WB_ADDR_W-1:0]     mTag   [WB_BUFS][WB_ENTRIES];
  logic [LINE_W-1:0]        mData  [WB_BUFS][WB_ENTRIES];
  logic [WB_LINE_BYTES-1:0] mMask  [WB_BUFS][WB_ENTRIES];
  bit mBusy [WB_BUFS];
  bit mDone [WB_BUFS];
  int mOrd[$];
  int l2Log[$];

  int nChecks = 0, nFails = 0;
  string phase = "reset";
  int lastGrant = 0;
  bit lastStall = 0, lastReady = 0, lastL2 = 0;
  bit finished = 0;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s (%s) actual=%h expected=%h", what, phase, act, exp);
    end
  endtask

  function automatic bit ownedLive(input int b);
    return b < WB_BUFS && mBusy[b] && !mDone[b];
  endfunction

  task automatic idle();
    allocValid = 0; stValid = 0; commitValid = 0; violValid = 0;
  endtask

  // one clock: compare outputs mid-cycle, then advance the model at the edge
  task automatic cycle();
    int fb, hb, hi, sb, vb, cb, hitE, freeE;
    bit expReady, headDone, expL2, violHit, stLive, expStall, commitHit, allocGo;
    #1;
    fb = -1;
    for (int i = WB_BUFS - 1; i >= 0; i--) if (!mBusy[i]) fb = i;
    expReady = (fb >= 0);
    check("R1 allocReady", allocReady, expReady);
    if (expReady) check("R1 allocBuf", allocBuf, fb);
    hb = -1; hi = -1;
    if (mOrd.size() > 0) hb = mOrd[0];
    headDone = (hb >= 0) && mDone[hb];
    if (headDone)
      for (int e = WB_ENTRIES - 1; e >= 0; e--) if (mValid[hb][e]) hi = e;
    expL2 = headDone && (hi >= 0);
    check("R2 l2Valid", l2Valid, expL2);
    if (expL2) begin
      check("R3 l2Addr", l2Addr, mTag[hb][hi]);
      check("R6 l2Mask", l2Mask, mMask[hb][hi]);
      check("R6 l2Data", l2Data, mData[hb][hi]);
    end
    sb = int'(stBuf); vb = int'(violBuf); cb = int'(commitBuf);
    violHit = violValid && ownedLive(vb);
    stLive = stValid && ownedLive(sb) && !(violHit && vb == sb);
    hitE = -1; freeE = -1;
    if (stLive)
      for (int e = WB_ENTRIES - 1; e >= 0; e--) begin
        if (mValid[sb][e] && mTag[sb][e] == stAddr) hitE = e;
        if (!mValid[sb][e]) freeE = e;
      end
    expStall = stLive && hitE < 0 && freeE < 0;
    check("R7 stStall", stStall, expStall);
    commitHit = commitValid && cb < WB_BUFS && mBusy[cb] && !mDone[cb];
    allocGo = allocValid && expReady;
    lastStall = stStall; lastReady = allocReady; lastL2 = l2Valid;
    if (l2Valid) l2Log.push_back(int'(l2Addr));
    @(posedge clk);
    if (violHit) for (int e = 0; e < WB_ENTRIES; e++) mValid[vb][e] = 0;
    if (stLive && !expStall) begin
      if (hitE >= 0) begin
        for (int k = 0; k < WB_LINE_BYTES; k++)
          if (stMask[k]) mData[sb][hitE][k*8 +: 8] = stData[k*8 +: 8];
        mMask[sb][hitE] = mMask[sb][hitE] | stMask;
      end else begin
        mValid[sb][freeE] = 1;
        mTag[sb][freeE] = stAddr;
        mMask[sb][freeE] = stMask;
        for (int k = 0; k < WB_LINE_BYTES; k++)
          mData[sb][freeE][k*8 +: 8] = stMask[k] ? stData[k*8 +: 8] : 8'h00;
      end
    end
    if (expL2) mValid[hb][hi] = 0;
    else if (headDone) begin
      mBusy[hb] = 0; mDone[hb] = 0;
      void'(mOrd.pop_front());
    end
    if (commitHit) mDone[cb] = 1;
    if (allocGo) begin
      mBusy[fb] = 1; mDone[fb] = 0;
      mOrd.push_back(fb);
      lastGrant = fb;
    end
    @(negedge clk);
  endtask

  task automatic doAlloc();
    idle(); allocValid = 1; cycle(); idle();
  endtask

  task automatic doStore(input int b, input int a, input logic [63:0] d, input logic [7:0] m);
    idle(); stValid = 1; stBuf = BUF_W'(b); stAddr = WB_ADDR_W'(a);
    stData = LINE_W'(d); stMask = WB_LINE_BYTES'(m);
    cycle(); idle();
  endtask

  task automatic doCommit(input int b);
    idle(); commitValid = 1; commitBuf = BUF_W'(b); cycle(); idle();
  endtask

  task automatic runIdle(input int n);
    idle();
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic drainAll();
    int pick;
    for (int n = 0; n < 400; n++) begin
      pick = -1;
      foreach (mOrd[i]) if (pick < 0 && !mDone[mOrd[i]]) pick = mOrd[i];
      if (pick >= 0) doCommit(pick);
      else if (mOrd.size() == 0) break;
      else runIdle(1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired (%s)", phase);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int a, b0, b1, pick;
    void'($urandom(32'd20240611));
    foreach (mBusy[i]) begin mBusy[i] = 0; mDone[i] = 0; end
    foreach (mValid[i, j]) begin
      mValid[i][j] = 0; mTag[i][j] = '0; mData[i][j] = '0; mMask[i][j] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state: R1 R2 R7
    phase = "reset R1 R2";
    runIdle(1);

    // commit order reversed against claim order: R2 R3 R6
    phase = "order R2 R3 R6";
    doAlloc(); b0 = lastGrant;
    doAlloc(); b1 = lastGrant;
    doStore(b1, 'h20, 64'h1111_2222_3333_4444, 8'h0F);
    doStore(b0, 'h10, 64'h0102_0304_0506_0708, 8'hFF);
    doStore(b0, 'h10, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0C);
    l2Log.delete();
    doCommit(b1);
    runIdle(4);
    check("R2 younger held back", l2Log.size(), 0);
    doCommit(b0);
    runIdle(8);
    check("R3 write count", l2Log.size(), 2);
    if (l2Log.size() == 2) begin
      check("R3 older first", l2Log[0], 'h10);
      check("R3 younger second", l2Log[1], 'h20);
    end

    // capacity stall and merge: R7 R8
    phase = "full R7 R8";
    doAlloc(); b0 = lastGrant;
    for (int i = 0; i < WB_ENTRIES; i++) doStore(b0, 'h100 + i, 64'h55 << (8 * i), 8'h01 << i);
    doStore(b0, 'h180, 64'hFFFF, 8'h03);
    check("R7 stall on full buffer", lastStall, 1);
    doStore(b0, 'h102, 64'h7700_0000, 8'h08);
    check("R7 merge does not stall", lastStall, 0);
    l2Log.delete();
    drainAll();
    check("R8 one write per entry", l2Log.size(), WB_ENTRIES);
    if (l2Log.size() == WB_ENTRIES) check("R8 entry order", l2Log[0], 'h100);

    // violation with simultaneous store: R5
    phase = "violation R5";
    doAlloc(); b0 = lastGrant;
    doAlloc(); b1 = lastGrant;
    doStore(b0, 'h200, 64'h1, 8'h01);
    doStore(b1, 'h300, 64'h2, 8'h01);
    idle(); violValid = 1; violBuf = BUF_W'(b0);
    stValid = 1; stBuf = BUF_W'(b0); stAddr = 'h201; stData = 64'h3; stMask = 8'h01;
    cycle(); idle();
    doStore(b0, 'h202, 64'h4, 8'h01);
    l2Log.delete();
    doCommit(b1); doCommit(b0);
    runIdle(6);
    check("R5 write count", l2Log.size(), 2);
    if (l2Log.size() == 2) begin
      check("R5 only post-violation line", l2Log[0], 'h202);
      check("R5 other buffer intact", l2Log[1], 'h300);
    end

    // every buffer owned, drain concurrent with stores: R4
    phase = "spare R4";
    for (int i = 0; i < WB_BUFS; i++) doAlloc();
    runIdle(1);
    check("R4 no buffer left", lastReady, 0);
    foreach (mOrd[i]) doStore(mOrd[i], 'h400 + i, 64'h9, 8'h01);
    doCommit(mOrd[0]);
    idle(); stValid = 1; stBuf = BUF_W'(mOrd[1]); stAddr = 'h480; stData = 64'h5; stMask = 8'h01;
    cycle(); idle();
    check("R4 drain active", lastL2, 1);
    check("R4 store accepted meanwhile", lastStall, 0);
    drainAll();

    // stores and commits to buffers nobody owns: R9
    phase = "ignored R9";
    l2Log.delete();
    doStore(6, 'h500, 64'h1, 8'h01);
    doStore(2, 'h501, 64'h1, 8'h01);
    doCommit(2);
    runIdle(4);
    check("R9 nothing written", l2Log.size(), 0);
    doAlloc(); b0 = lastGrant;
    doStore(b0, 'h510, 64'h6, 8'h01);
    doCommit(b0);
    doStore(b0, 'h511, 64'h7, 8'h01);
    runIdle(4);
    check("R9 finished buffer takes no stores", l2Log.size(), 1);

    // random traffic: R1 R2 R3 R5 R6 R7
    phase = "random R1 R2 R3 R5 R6 R7";
    for (int n = 0; n < 4000; n++) begin
      idle();
      allocValid = ($urandom % 4) == 0;
      stValid = ($urandom % 2) == 0;
      stBuf = BUF_W'($urandom % 8);
      a = $urandom % 6;
      stAddr = WB_ADDR_W'('h600 + a);
      stData = {$urandom, $urandom};
      stMask = WB_LINE_BYTES'($urandom);
      commitValid = ($urandom % 6) == 0;
      pick = $urandom % 8;
      if (mOrd.size() > 0 && ($urandom % 4) != 0) pick = mOrd[$urandom % mOrd.size()];
      commitBuf = BUF_W'(pick);
      violValid = ($urandom % 20) == 0;
      violBuf = BUF_W'($urandom % WB_BUFS);
      cycle();
    end
    idle();
    drainAll();
    runIdle(4);
    check("R3 pool empty at end", lastReady, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule